// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Engine

This engine moves audio samples between a local sample FIFO and a circular buffer in system memory. Every transfer is one burst of a fixed byte count. A small register file sets the buffer bounds, how full the FIFO must be before a burst starts, and how many bursts make one period. The FIFO storage is outside the block. Only its fill level, in bytes, enters the block.

Once the engine is enabled, it raises a request on a request/acknowledge memory port whenever the FIFO level reaches the programmed threshold. The address is held until the burst is acknowledged. The pointer then steps by one burst. After the burst at the inclusive finish address, the pointer returns to the start address. Two sticky status sources can raise a level interrupt: period complete and buffer wrapped. Each source is cleared by writing its clear bit high and then low again. A selectable position register lets software read the live pointer to track playback or capture.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset, `mem_req` and `irq` are low, and the status register (index 6) and position register (index 7) read zero.
- R2: No new burst request is raised while the enable bit (CTRL index 0, bit 0) is clear. A request that is already raised stays high until it is acknowledged.
- R3: While enabled with no request pending, a request rises on the next clock once `fifo_level` is at least (threshold field + 1) × BURST_BYTES. The threshold field is CTRL bits [11:8].
- R4: `mem_req` and `mem_addr` hold steady until `mem_ack`. The acknowledge cycle advances the pointer by BURST_BYTES.
- R5: After the burst at the finish address (index 3) is acknowledged, the next address is the start address (index 2). The same acknowledge sets the wrap status bit (status bit 1).
- R6: Each time the period count N (index 4) of bursts completes, the period status bit (status bit 0) is set. With N = 0, the period bit is never set.
- R7: While a clear bit (index 1, bit i) is high, status bit i is forced to zero. An event that occurs while the clear bit is high is lost.
- R8: `irq` is high exactly when some status bit is set and its enable is set. The enables are CTRL bits [2:1], where bit 1 enables period and bit 2 enables wrap.
- R9: The position register follows the select field (CTRL bits [5:4]): 0 reports the current pointer, 1 the burst count within the period, 2 `fifo_level`, and 3 zero.
- R10: While disabled, a write to the start address or to the initial address (index 5) loads the pointer with the written value and clears the burst count.
- R11: Clearing and then setting the enable bit resumes transfers at the pointer where they stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| fifo_level | input | LEVEL_W | Bytes currently held in the sample FIFO |
| mem_req | output | 1 | Burst request |
| mem_addr | output | ADDR_W | Byte address of the requested burst |
| mem_ack | input | 1 | Burst acknowledge |
| irq | output | 1 | Level interrupt |

## Verification
Two things can happen on the same acknowledge edge: the wrap back to the start address and the completion of a period. Both status bits must then set together. The bench provokes this by sweeping every buffer length from one to four bursts against every period count from one to three. It predicts the address, the pointer and both sticky bits arithmetically after every burst, so the coinciding cases are judged alongside the rest. A second overlap is a period completing while the period clear bit is held high. The bench checks that this event is dropped rather than deferred.

// File: rtl/adma_pkg.sv
package adma_pkg;

   localparam int REG_IDX_W  = 3;
   localparam int NUM_IRQ    = 2;
   localparam int IRQ_PERIOD = 0;
   localparam int IRQ_WRAP   = 1;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_IEN_LSB = 1;
   localparam int CTRL_SEL_LSB = 4;
   localparam int CTRL_THR_LSB = 8;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_CTRL   = 3'd0,
      REG_CLR    = 3'd1,
      REG_START  = 3'd2,
      REG_FINISH = 3'd3,
      REG_PERIOD = 3'd4,
      REG_INIT   = 3'd5,
      REG_STATUS = 3'd6,
      REG_POS    = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      POS_PTR   = 2'd0,
      POS_COUNT = 2'd1,
      POS_LEVEL = 2'd2,
      POS_NONE  = 2'd3
   } pos_sel_e;

endpackage

// File: rtl/adma_burst_trigger.sv
module adma_burst_trigger #(
   parameter int LEVEL_W     = 9,
   parameter int THR_W       = 4,
   parameter int BURST_BYTES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dma_en,
   input  logic [THR_W-1:0]   thr,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               mem_ack,
   output logic               mem_req,
   output logic               done
);

   localparam int BB_LOG = (BURST_BYTES > 1) ? $clog2(BURST_BYTES) : 1;
   localparam int CMP_W  = LEVEL_W + THR_W + BB_LOG + 1;

   logic [CMP_W-1:0] need_bytes;
   logic             level_ok;
   logic             req_q;

   assign need_bytes = (CMP_W'(thr) + CMP_W'(1)) * CMP_W'(BURST_BYTES);
   assign level_ok   = CMP_W'(fifo_level) >= need_bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (req_q) begin
         if (mem_ack) req_q <= 1'b0;
      end else if (dma_en && level_ok) begin
         req_q <= 1'b1;
      end
   end

   assign mem_req = req_q;
   assign done    = req_q & mem_ack;

endmodule

// File: rtl/adma_ring_ptr.sv
module adma_ring_ptr #(
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] finish_addr,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic              wrapped
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

   logic [ADDR_W-1:0] ptr_q;
   logic              at_end;

   assign at_end = (ptr_q == finish_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (load) begin
         ptr_q <= load_val;
      end else if (step) begin
         ptr_q <= at_end ? start_addr : ptr_q + STEP;
      end
   end

   assign ptr     = ptr_q;
   assign wrapped = step & at_end & ~load;

endmodule

// File: rtl/adma_period_cnt.sv
module adma_period_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [CNT_W-1:0] period_n,
   output logic [CNT_W-1:0] count,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   assign last = (period_n != '0) && (cnt_q == period_n - CNT_W'(1));
   assign tick = step & last & ~clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/adma_irq_ctrl.sv
module adma_irq_ctrl #(
   parameter int NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] evt,
   input  logic [NUM-1:0] clr,
   input  logic [NUM-1:0] en,
   output logic [NUM-1:0] sts,
   output logic           irq
);

   for (genvar i = 0; i < NUM; i++) begin : g_src
      logic sts_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sts_q <= 1'b0;
         else if (clr[i]) sts_q <= 1'b0;
         else if (evt[i]) sts_q <= 1'b1;
      end
      assign sts[i] = sts_q;
   end

   assign irq = |(sts & en);

endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
   import adma_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int BURST_BYTES = 8,
   parameter int LEVEL_W     = 9,
   parameter int THR_W       = 4,
   parameter int CNT_W       = 16,
   parameter bit HAS_INIT    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [LEVEL_W-1:0]   fifo_level,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_ack,
   output logic                 irq
);

   if (BURST_BYTES < 1 || (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_bad_burst
      $error("BURST_BYTES must be a power of two");
   end
   if (ADDR_W > DATA_W || CNT_W > DATA_W || LEVEL_W > DATA_W) begin : g_bad_width
      $error("ADDR_W, CNT_W and LEVEL_W must fit in DATA_W");
   end
   if (CTRL_THR_LSB + THR_W > DATA_W) begin : g_bad_thr
      $error("threshold field does not fit in the control word");
   end

   reg_idx_e              widx;
   logic                  dma_en_q;
   logic [NUM_IRQ-1:0]    ien_q;
   logic [NUM_IRQ-1:0]    clr_q;
   pos_sel_e              sel_q;
   logic [THR_W-1:0]      thr_q;
   logic [ADDR_W-1:0]     start_q;
   logic [ADDR_W-1:0]     finish_q;
   logic [CNT_W-1:0]      period_q;
   logic [ADDR_W-1:0]     init_q;
   logic                  init_load;
   logic                  ptr_load;
   logic                  burst_done;
   logic [ADDR_W-1:0]     ptr;
   logic                  wrapped;
   logic [CNT_W-1:0]      count;
   logic                  period_tick;
   logic [NUM_IRQ-1:0]    evt;
   logic [NUM_IRQ-1:0]    sts;

   assign widx = reg_idx_e'(reg_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_en_q <= 1'b0;
         ien_q    <= '0;
         clr_q    <= '0;
         sel_q    <= POS_PTR;
         thr_q    <= '0;
         start_q  <= '0;
         finish_q <= '0;
         period_q <= '0;
      end else if (reg_we) begin
         case (widx)
            REG_CTRL: begin
               dma_en_q <= reg_wdata[CTRL_EN_BIT];
               ien_q    <= reg_wdata[CTRL_IEN_LSB +: NUM_IRQ];
               sel_q    <= pos_sel_e'(reg_wdata[CTRL_SEL_LSB +: 2]);
               thr_q    <= reg_wdata[CTRL_THR_LSB +: THR_W];
            end
            REG_CLR:    clr_q    <= reg_wdata[NUM_IRQ-1:0];
            REG_START:  start_q  <= reg_wdata[ADDR_W-1:0];
            REG_FINISH: finish_q <= reg_wdata[ADDR_W-1:0];
            REG_PERIOD: period_q <= reg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   if (HAS_INIT) begin : g_init
      logic [ADDR_W-1:0] init_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          init_r <= '0;
         else if (reg_we && widx == REG_INIT) init_r <= reg_wdata[ADDR_W-1:0];
      end
      assign init_q    = init_r;
      assign init_load = reg_we && (widx == REG_INIT);
   end else begin : g_no_init
      assign init_q    = '0;
      assign init_load = 1'b0;
   end

   assign ptr_load = !dma_en_q && reg_we && ((widx == REG_START) || init_load);

   adma_burst_trigger #(
      .LEVEL_W    (LEVEL_W),
      .THR_W      (THR_W),
      .BURST_BYTES(BURST_BYTES)
   ) u_trig (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_en    (dma_en_q),
      .thr       (thr_q),
      .fifo_level(fifo_level),
      .mem_ack   (mem_ack),
      .mem_req   (mem_req),
      .done      (burst_done)
   );

   adma_ring_ptr #(
      .ADDR_W     (ADDR_W),
      .BURST_BYTES(BURST_BYTES)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_q),
      .finish_addr(finish_q),
      .load       (ptr_load),
      .load_val   (reg_wdata[ADDR_W-1:0]),
      .step       (burst_done),
      .ptr        (ptr),
      .wrapped    (wrapped)
   );

   adma_period_cnt #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (ptr_load),
      .step    (burst_done),
      .period_n(period_q),
      .count   (count),
      .tick    (period_tick)
   );

   assign evt[IRQ_PERIOD] = period_tick;
   assign evt[IRQ_WRAP]   = wrapped;

   adma_irq_ctrl #(
      .NUM(NUM_IRQ)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt),
      .clr  (clr_q),
      .en   (ien_q),
      .sts  (sts),
      .irq  (irq)
   );

   assign mem_addr = ptr;

   always_comb begin
      reg_rdata = '0;
      case (widx)
         REG_CTRL: begin
            reg_rdata[CTRL_EN_BIT]                = dma_en_q;
            reg_rdata[CTRL_IEN_LSB +: NUM_IRQ]    = ien_q;
            reg_rdata[CTRL_SEL_LSB +: 2]          = sel_q;
            reg_rdata[CTRL_THR_LSB +: THR_W]      = thr_q;
         end
         REG_CLR:    reg_rdata[NUM_IRQ-1:0] = clr_q;
         REG_START:  reg_rdata[ADDR_W-1:0]  = start_q;
         REG_FINISH: reg_rdata[ADDR_W-1:0]  = finish_q;
         REG_PERIOD: reg_rdata[CNT_W-1:0]   = period_q;
         REG_INIT:   reg_rdata[ADDR_W-1:0]  = init_q;
         REG_STATUS: reg_rdata[NUM_IRQ-1:0] = sts;
         REG_POS: begin
            case (sel_q)
               POS_PTR:   reg_rdata[ADDR_W-1:0]  = ptr;
               POS_COUNT: reg_rdata[CNT_W-1:0]   = count;
               POS_LEVEL: reg_rdata[LEVEL_W-1:0] = fifo_level;
               default:   reg_rdata = '0;
            endcase
         end
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/adma_checker.sv
module adma_checker #(
   parameter int ADDR_W      = 32,
   parameter int BURST_BYTES = 8,
   parameter int LEVEL_W     = 9,
   parameter int THR_W       = 4,
   parameter int NUM         = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic               dma_en,
   input logic [THR_W-1:0]   thr,
   input logic [LEVEL_W-1:0] fifo_level,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic [ADDR_W-1:0]  start_addr,
   input logic [ADDR_W-1:0]  finish_addr,
   input logic [NUM-1:0]     clr,
   input logic [NUM-1:0]     sts,
   input logic [NUM-1:0]     en,
   input logic               irq
);

   localparam int CW = LEVEL_W + THR_W + 8;
   logic lvl_ok;
   assign lvl_ok = CW'(fifo_level) >= (CW'(thr) + CW'(1)) * CW'(BURST_BYTES);

   p_no_start_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_en && !mem_req) |=> !mem_req);

   p_start_on_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && !mem_req && lvl_ok) |=> mem_req);

   p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !reg_we) |=> (mem_req && $stable(mem_addr)));

   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !reg_we && mem_addr != finish_addr)
      |=> mem_addr == $past(mem_addr) + ADDR_W'(BURST_BYTES));

   p_wrap_to_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !reg_we && mem_addr == finish_addr)
      |=> mem_addr == $past(start_addr));

   p_clear_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr[0] |=> !sts[0]);

   p_clear_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr[1] |=> !sts[1]);

   p_masked_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);

endmodule

bind audio_ring_dma adma_checker #(
   .ADDR_W     (ADDR_W),
   .BURST_BYTES(BURST_BYTES),
   .LEVEL_W    (LEVEL_W),
   .THR_W      (THR_W),
   .NUM        (adma_pkg::NUM_IRQ)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .dma_en     (dma_en_q),
   .thr        (thr_q),
   .fifo_level (fifo_level),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .start_addr (start_q),
   .finish_addr(finish_q),
   .clr        (clr_q),
   .sts        (sts),
   .en         (ien_q),
   .irq        (irq)
);

// File: tb/audio_ring_dma_test.sv
module audio_ring_dma_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [8:0]  fifo_level = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   audio_ring_dma uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_level(fifo_level),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
   );

   localparam logic [2:0] I_CTRL = 3'd0, I_CLR = 3'd1, I_START = 3'd2,
      I_FINISH = 3'd3, I_PERIOD = 3'd4, I_INIT = 3'd5, I_STS = 3'd6, I_POS = 3'd7;

   function automatic logic [31:0] ctrl_word(bit en, logic [1:0] ien,
                                             logic [1:0] sel, logic [3:0] thr);
      return {20'd0, thr, 2'b00, sel, 1'b0, ien, en};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [31:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = idx; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [31:0] v);
      reg_addr = idx;
      #1;
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic burst(input logic [31:0] exp, input string tag);
      int w = 0;
      while (!mem_req && w < 50) begin
         @(negedge clk);
         w++;
      end
      chk({tag, " request"}, mem_req, 1);
      chk({tag, " address"}, mem_addr, exp);
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 mem_req", mem_req, 0);
      chk("R1 irq", irq, 0);
      rd(I_STS, v); chk("R1 status", v, 0);
      rd(I_POS, v); chk("R1 position", v, 0);

      // R2 disabled: no request with a full fifo
      wr(I_START, 32'h100);
      wr(I_FINISH, 32'h100 + 7 * 8);
      wr(I_PERIOD, 32'd0);
      fifo_level = 9'd256;
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
      idle(5);
      chk("R2 no request while disabled", mem_req, 0);

      // R3 threshold sweep
      for (int t = 0; t < 4; t++) begin
         fifo_level = 9'((t + 1) * 8 - 1);
         wr(I_CTRL, ctrl_word(1, 2'b00, 2'd0, 4'(t)));
         idle(4);
         chk("R3 below threshold", mem_req, 0);
         fifo_level = 9'((t + 1) * 8);
         idle(1);
         chk("R3 at threshold", mem_req, 1);
         burst(32'h100 + 32'(t * 8), "R3 burst");
         fifo_level = '0;
         wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
      end

      // R4 R5 R6 sweep: buffer length L bursts against period N bursts
      for (int L = 1; L <= 4; L++) begin
         for (int N = 1; N <= 3; N++) begin
            fifo_level = '0;
            wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
            wr(I_START, 32'h200);
            wr(I_FINISH, 32'h200 + 32'((L - 1) * 8));
            wr(I_PERIOD, 32'(N));
            wr(I_CLR, 32'd3);
            wr(I_CLR, 32'd0);
            wr(I_CTRL, ctrl_word(1, 2'b00, 2'd0, 4'd0));
            fifo_level = 9'd256;
            for (int k = 0; k <= L * N; k++) begin
               burst(32'h200 + 32'((k % L) * 8), "R4 R5 sweep");
               rd(I_STS, v);
               chk("R6 period status", 32'(v[0]), 32'(k + 1 >= N));
               chk("R5 wrap status", 32'(v[1]), 32'(k + 1 >= L));
               rd(I_POS, v);
               chk("R4 pointer", v, 32'h200 + 32'(((k + 1) % L) * 8));
            end
            fifo_level = '0;
         end
      end

      // R7 clear held high drops events; R8 interrupt masking
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
      wr(I_START, 32'h500);
      wr(I_FINISH, 32'h5F8);
      wr(I_PERIOD, 32'd2);
      wr(I_CLR, 32'd3);
      wr(I_CLR, 32'd1);
      wr(I_CTRL, ctrl_word(1, 2'b00, 2'd0, 4'd0));
      fifo_level = 9'd256;
      burst(32'h500, "R7 burst");
      burst(32'h508, "R7 burst");
      fifo_level = '0;
      rd(I_STS, v); chk("R7 event lost while clear high", v, 0);
      wr(I_CLR, 32'd0);
      rd(I_STS, v); chk("R7 still clear after release", v, 0);
      fifo_level = 9'd256;
      burst(32'h510, "R7 burst");
      burst(32'h518, "R7 burst");
      fifo_level = '0;
      rd(I_STS, v); chk("R7 set again after release", v, 1);
      chk("R8 irq masked", irq, 0);
      wr(I_CTRL, ctrl_word(1, 2'b01, 2'd0, 4'd0));
      chk("R8 irq period enabled", irq, 1);
      wr(I_CTRL, ctrl_word(1, 2'b10, 2'd0, 4'd0));
      chk("R8 irq wrap enabled only", irq, 0);
      wr(I_CTRL, ctrl_word(1, 2'b01, 2'd0, 4'd0));
      wr(I_CLR, 32'd1);
      idle(1);
      rd(I_STS, v); chk("R7 clear removes status", v, 0);
      chk("R8 irq drops after clear", irq, 0);
      wr(I_CLR, 32'd0);

      // R11 pause/resume, R2 pending request, R9 selector, R6 N=0
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd1, 4'd0));
      wr(I_START, 32'h400);
      wr(I_FINISH, 32'h438);
      wr(I_PERIOD, 32'd0);
      wr(I_CLR, 32'd3);
      wr(I_CLR, 32'd0);
      wr(I_CTRL, ctrl_word(1, 2'b00, 2'd1, 4'd0));
      fifo_level = 9'd256;
      burst(32'h400, "R11 burst");
      burst(32'h408, "R11 burst");
      fifo_level = '0;
      rd(I_POS, v); chk("R9 burst count", v, 2);
      idle(3);
      chk("R11 idle at low level", mem_req, 0);
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd2, 4'd0));
      fifo_level = 9'd256;
      idle(5);
      chk("R2 paused no request", mem_req, 0);
      rd(I_POS, v); chk("R9 fifo level", v, 256);
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd3, 4'd0));
      rd(I_POS, v); chk("R9 zero select", v, 0);
      wr(I_CTRL, ctrl_word(1, 2'b00, 2'd0, 4'd0));
      burst(32'h410, "R11 resume address");
      idle(1);
      chk("R2 next request raised", mem_req, 1);
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
      idle(3);
      chk("R2 pending request held", mem_req, 1);
      chk("R4 pending address held", mem_addr, 32'h418);
      burst(32'h418, "R2 pending burst");
      idle(3);
      chk("R2 no request after pending ack", mem_req, 0);
      rd(I_STS, v); chk("R6 no period with N=0", 32'(v[0]), 0);
      fifo_level = '0;

      // R10 start reload clears count, initial address loads pointer
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd1, 4'd0));
      wr(I_START, 32'h300);
      rd(I_POS, v); chk("R10 count cleared", v, 0);
      wr(I_CTRL, ctrl_word(0, 2'b00, 2'd0, 4'd0));
      rd(I_POS, v); chk("R10 pointer at start", v, 32'h300);
      wr(I_FINISH, 32'h318);
      wr(I_INIT, 32'h310);
      rd(I_POS, v); chk("R10 pointer at initial", v, 32'h310);
      wr(I_CTRL, ctrl_word(1, 2'b00, 2'd0, 4'd0));
      fifo_level = 9'd256;
      burst(32'h310, "R10 first burst");
      burst(32'h318, "R10 second burst");
      burst(32'h300, "R5 wrap after initial");
      fifo_level = '0;
      idle(2);

      finish_run();
   end

endmodule